// File: doc/BRIEF.md
# Command-Driven I2C Bus Master

This block is a byte-level I2C master steered by a host through one-shot command requests. The host can start a transaction, issue a repeated start, end it with a stop, send an acknowledge or not-acknowledge bit, shift a byte out, or shift a byte in. Each request raises a command bit that the block clears by itself once the action has finished on the wire. A transaction is assembled by the host as a chain of these actions, polling the command bits or the idle indication between steps.

The block drives SCL and SDA only as open-drain pull-down enables and reads SDA back from the bus. Bit timing comes from a reload value N: every bit period is four quarter phases of N+1 clocks, so the SCL rate is Fclk / (4 * (N + 1)). Status outputs show transmit activity, a shared buffer-full flag, a sticky completion flag for transmitted bytes and the acknowledge level returned by the addressed device.

Top module: `i2c_cmd_master`

## Requirements
- R1: After reset all command bits, tx_busy_o, buf_full_o and done_o are 0, idle_o is 1 and both line enables are 0 (lines released).
- R2: A quarter phase lasts reload_i+1 clocks; start and stop each take 4 quarters, a repeated start 6 quarters, an acknowledge 4, a byte receive 32 and a byte transmit 36 quarters, measured from the accepting edge to the edge that clears the busy bit.
- R3: A start lowers SDA while SCL is high; a stop raises SDA while SCL is high; a repeated start releases SDA with SCL low, raises SCL, then lowers SDA with SCL high. Outside these three actions SDA changes only while SCL is held low.
- R4: A write on tx_wr_i sends tx_byte_i most significant bit first as 8 SCL pulses, then a 9th pulse with SDA released; tx_busy_o stays 1 across all 9 bits and done_o sets only when the 9th bit has finished.
- R5: The SDA level sampled in the 9th bit of a transmit is kept on ack_stat_o: 0 means acknowledged, 1 means not acknowledged.
- R6: During a transmit, buf_full_o is 1 throughout the 8 data bits and 0 during the 9th (acknowledge) bit.
- R7: A receive shifts 8 bits in, most significant first, sampling SDA while SCL is high; on completion rx_bit_o clears, buf_full_o sets and rx_byte_o holds the byte. A pulse on rx_rd_i clears buf_full_o.
- R8: The acknowledge action drives the ack_val_i level captured at launch for one bit time: 0 pulls SDA low, 1 leaves SDA released.
- R9: Requests are not queued: a command request or tx_wr_i arriving while any action is in progress is discarded and never starts later.
- R10: idle_o is 1 exactly when no command bit and tx_busy_o are set.
- R11: Line outputs are pull-down enables only; after start, repeated start, byte or acknowledge actions SCL stays held low, and after a stop both lines are released.
- R12: done_o stays set until a pulse on done_clr_i clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reload_i | input | RELOAD_W | Quarter-phase reload N |
| start_req_i | input | 1 | Request a start |
| rstart_req_i | input | 1 | Request a repeated start |
| stop_req_i | input | 1 | Request a stop |
| ack_req_i | input | 1 | Request an acknowledge bit |
| rx_req_i | input | 1 | Request a byte receive |
| ack_val_i | input | 1 | Acknowledge level to send (0 ACK, 1 NAK) |
| tx_wr_i | input | 1 | Write transmit byte and start sending |
| tx_byte_i | input | BYTE_W | Byte to transmit |
| rx_rd_i | input | 1 | Host read of the receive buffer |
| done_clr_i | input | 1 | Clear the completion flag |
| start_bit_o | output | 1 | Start command in progress |
| rstart_bit_o | output | 1 | Repeated start in progress |
| stop_bit_o | output | 1 | Stop in progress |
| ack_bit_o | output | 1 | Acknowledge bit in progress |
| rx_bit_o | output | 1 | Receive in progress |
| tx_busy_o | output | 1 | Transmit in progress |
| buf_full_o | output | 1 | Buffer full |
| done_o | output | 1 | Transmit plus acknowledge finished |
| ack_stat_o | output | 1 | Acknowledge level returned by device |
| idle_o | output | 1 | No action in progress |
| rx_byte_o | output | BYTE_W | Received byte |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe_o | output | 1 | Pull SCL low |
| sda_oe_o | output | 1 | Pull SDA low |

## Verification
The hardest situations to reach are the discarded requests: a transmit write or a stop arriving while a start is still on the wire, and a start request in the middle of a byte, since the host interface normally waits for idle first. The bench injects those pulses a few cycles into an action and then confirms on the bus model that no extra byte, stop or start appeared and that the block returns to idle. A second hard point is the acknowledge bit, where the device model must take SDA at exactly the falling SCL edge after the eighth bit; the bus model counts SCL edges itself and answers with ACK or NAK, which also exposes the buffer-full drop in the 9th bit.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [2:0] {
    OP_NONE,
    OP_START,
    OP_RSTART,
    OP_STOP,
    OP_ACK,
    OP_TX,
    OP_RX
  } op_e;

  function automatic logic is_cond(op_e o);
    return (o == OP_START) || (o == OP_RSTART) || (o == OP_STOP);
  endfunction
endpackage

// File: rtl/i2cm_quarter_timer.sv
module i2cm_quarter_timer #(
  parameter int RELOAD_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic [RELOAD_W-1:0] reload_i,
  output logic                tick_o
);
  logic [RELOAD_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == reload_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // quarter length is reload+1, so ticks are spaced apart unless reload is 0
  p_tick_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && reload_i != '0) |=> (!tick_o || reload_i != $past(reload_i)));
endmodule

// File: rtl/i2cm_cmd_pick.sv
module i2cm_cmd_pick import i2cm_pkg::*; (
  input  logic idle_i,
  input  logic start_i,
  input  logic rstart_i,
  input  logic stop_i,
  input  logic ack_i,
  input  logic rx_i,
  input  logic tx_i,
  output op_e  op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (idle_i) begin
      if (start_i)       op_o = OP_START;
      else if (rstart_i) op_o = OP_RSTART;
      else if (stop_i)   op_o = OP_STOP;
      else if (ack_i)    op_o = OP_ACK;
      else if (rx_i)     op_o = OP_RX;
      else if (tx_i)     op_o = OP_TX;
    end
  end
endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine import i2cm_pkg::*; #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  op_e               grant_i,
  input  logic              tick_i,
  input  logic              ack_val_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              rx_rd_i,
  input  logic              done_clr_i,
  input  logic              sda_i,
  output op_e               op_o,
  output logic              buf_full_o,
  output logic              done_o,
  output logic              ack_stat_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              scl_oe_o,
  output logic              sda_oe_o
);
  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] TX_LAST = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] RX_LAST = BIT_W'(BYTE_W - 1);

  op_e               op_q;
  logic [1:0]        qph_q;
  logic [BIT_W-1:0]  bit_q;
  logic [BYTE_W-1:0] sh_q;
  logic              ackv_q, scl_hold_q, sda_hold_q;
  logic              buf_full_q, done_q, ack_stat_q;
  logic [BYTE_W-1:0] rx_q;
  logic              last, fin, sample, q_low;
  logic [2:0]        rs_step;

  always_comb begin
    case (op_q)
      OP_START, OP_STOP, OP_ACK: last = (qph_q == 2'd3);
      OP_RSTART:                 last = bit_q[0] && (qph_q == 2'd1);
      OP_TX:                     last = (bit_q == TX_LAST) && (qph_q == 2'd3);
      OP_RX:                     last = (bit_q == RX_LAST) && (qph_q == 2'd3);
      default:                   last = 1'b0;
    endcase
  end

  assign fin     = tick_i && last;
  assign sample  = tick_i && (qph_q == 2'd1);
  assign q_low   = (qph_q == 2'd0) || (qph_q == 2'd3);
  assign rs_step = {bit_q[0], qph_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q       <= OP_NONE;
      qph_q      <= '0;
      bit_q      <= '0;
      sh_q       <= '0;
      ackv_q     <= 1'b0;
      scl_hold_q <= 1'b0;
      sda_hold_q <= 1'b0;
      buf_full_q <= 1'b0;
      done_q     <= 1'b0;
      ack_stat_q <= 1'b0;
      rx_q       <= '0;
    end else begin
      if (done_clr_i)             done_q     <= 1'b0;
      if (rx_rd_i && op_q != OP_TX) buf_full_q <= 1'b0;
      if (op_q == OP_NONE) begin
        if (grant_i != OP_NONE) begin
          op_q  <= grant_i;
          qph_q <= '0;
          bit_q <= '0;
          if (grant_i == OP_TX) begin
            sh_q       <= tx_byte_i;
            buf_full_q <= 1'b1;
          end
          if (grant_i == OP_ACK) ackv_q <= ack_val_i;
        end
      end else if (tick_i) begin
        qph_q <= qph_q + 1'b1;
        if (qph_q == 2'd3) bit_q <= bit_q + 1'b1;
        if (op_q == OP_TX) begin
          if (sample && bit_q == TX_LAST) ack_stat_q <= sda_i;
          if (qph_q == 2'd3 && bit_q < TX_LAST) sh_q <= sh_q << 1;
          if (qph_q == 2'd3 && bit_q == RX_LAST) buf_full_q <= 1'b0;
        end
        if (op_q == OP_RX && sample) sh_q <= {sh_q[BYTE_W-2:0], sda_i};
        if (fin) begin
          op_q <= OP_NONE;
          case (op_q)
            OP_START, OP_RSTART: begin scl_hold_q <= 1'b1; sda_hold_q <= 1'b1; end
            OP_STOP:             begin scl_hold_q <= 1'b0; sda_hold_q <= 1'b0; end
            default:             begin scl_hold_q <= 1'b1; sda_hold_q <= 1'b0; end
          endcase
          if (op_q == OP_TX) done_q <= 1'b1;
          if (op_q == OP_RX) begin
            rx_q       <= sh_q;
            buf_full_q <= 1'b1;
          end
        end
      end
    end
  end

  // line enables per quarter: 1 pulls the line low
  always_comb begin
    case (op_q)
      OP_START:  begin scl_oe_o = (qph_q == 2'd3); sda_oe_o = qph_q[1]; end
      OP_RSTART: begin scl_oe_o = (rs_step < 3'd2) || (rs_step == 3'd5);
                       sda_oe_o = (rs_step >= 3'd4); end
      OP_STOP:   begin scl_oe_o = (qph_q == 2'd0); sda_oe_o = (qph_q != 2'd3); end
      OP_ACK:    begin scl_oe_o = q_low; sda_oe_o = !ackv_q; end
      OP_TX:     begin scl_oe_o = q_low;
                       sda_oe_o = (bit_q < TX_LAST) ? !sh_q[BYTE_W-1] : 1'b0; end
      OP_RX:     begin scl_oe_o = q_low; sda_oe_o = 1'b0; end
      default:   begin scl_oe_o = scl_hold_q; sda_oe_o = sda_hold_q; end
    endcase
  end

  assign op_o       = op_q;
  assign buf_full_o = buf_full_q;
  assign done_o     = done_q;
  assign ack_stat_o = ack_stat_q;
  assign rx_byte_o  = rx_q;

  p_sda_scl_low_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!is_cond(op_q) && !is_cond($past(op_q)) && (sda_oe_o != $past(sda_oe_o)))
      |-> (scl_oe_o && $past(scl_oe_o)));

  p_no_grant_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q != OP_NONE) |-> (grant_i == OP_NONE));

  p_bf_low_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_TX && bit_q == TX_LAST) |-> !buf_full_q);

  p_done_after_tx_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) |-> ($past(op_q) == OP_TX));

  p_rx_full_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_q == OP_RX && fin) |=> (buf_full_q && op_q == OP_NONE));
endmodule

// File: rtl/i2c_cmd_master.sv
module i2c_cmd_master import i2cm_pkg::*; #(
  parameter int RELOAD_W = 8,
  parameter int BYTE_W   = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [RELOAD_W-1:0] reload_i,
  input  logic                start_req_i,
  input  logic                rstart_req_i,
  input  logic                stop_req_i,
  input  logic                ack_req_i,
  input  logic                rx_req_i,
  input  logic                ack_val_i,
  input  logic                tx_wr_i,
  input  logic [BYTE_W-1:0]   tx_byte_i,
  input  logic                rx_rd_i,
  input  logic                done_clr_i,
  output logic                start_bit_o,
  output logic                rstart_bit_o,
  output logic                stop_bit_o,
  output logic                ack_bit_o,
  output logic                rx_bit_o,
  output logic                tx_busy_o,
  output logic                buf_full_o,
  output logic                done_o,
  output logic                ack_stat_o,
  output logic                idle_o,
  output logic [BYTE_W-1:0]   rx_byte_o,
  input  logic                scl_i,
  input  logic                sda_i,
  output logic                scl_oe_o,
  output logic                sda_oe_o
);
  op_e  grant, op;
  logic tick;

  i2cm_cmd_pick u_pick (
    .idle_i   (idle_o),
    .start_i  (start_req_i),
    .rstart_i (rstart_req_i),
    .stop_i   (stop_req_i),
    .ack_i    (ack_req_i),
    .rx_i     (rx_req_i),
    .tx_i     (tx_wr_i),
    .op_o     (grant)
  );

  i2cm_quarter_timer #(.RELOAD_W(RELOAD_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (op != OP_NONE),
    .reload_i (reload_i),
    .tick_o   (tick)
  );

  i2cm_engine #(.BYTE_W(BYTE_W)) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .grant_i    (grant),
    .tick_i     (tick),
    .ack_val_i  (ack_val_i),
    .tx_byte_i  (tx_byte_i),
    .rx_rd_i    (rx_rd_i),
    .done_clr_i (done_clr_i),
    .sda_i      (sda_i),
    .op_o       (op),
    .buf_full_o (buf_full_o),
    .done_o     (done_o),
    .ack_stat_o (ack_stat_o),
    .rx_byte_o  (rx_byte_o),
    .scl_oe_o   (scl_oe_o),
    .sda_oe_o   (sda_oe_o)
  );

  assign start_bit_o  = (op == OP_START);
  assign rstart_bit_o = (op == OP_RSTART);
  assign stop_bit_o   = (op == OP_STOP);
  assign ack_bit_o    = (op == OP_ACK);
  assign rx_bit_o     = (op == OP_RX);
  assign tx_busy_o    = (op == OP_TX);
  assign idle_o = !(start_bit_o | rstart_bit_o | stop_bit_o | ack_bit_o | rx_bit_o | tx_busy_o);

  // an enable must actually pull the wired line low
  p_scl_wired_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_o |-> !scl_i);
endmodule

// File: tb/i2c_cmd_master_bench.sv
`timescale 1ns/1ps
module i2c_cmd_master_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic [7:0] reload = 8'd2;
  logic start_req = 0, rstart_req = 0, stop_req = 0, ack_req = 0, rx_req = 0;
  logic ack_val = 0, tx_wr = 0, rx_rd = 0, done_clr = 0;
  logic [7:0] tx_byte = 8'h00;
  logic start_bit, rstart_bit, stop_bit, ack_bit, rx_bit, tx_busy;
  logic buf_full, done, ack_stat, idle_o, scl_oe, sda_oe;
  logic [7:0] rx_byte;
  logic slave_low = 1'b0;
  wire  scl_bus = ~scl_oe;
  wire  sda_bus = ~(sda_oe | slave_low);

  i2c_cmd_master u_i2c_cmd_master (
    .clk_i(clk), .rst_ni(rst_n), .reload_i(reload),
    .start_req_i(start_req), .rstart_req_i(rstart_req), .stop_req_i(stop_req),
    .ack_req_i(ack_req), .rx_req_i(rx_req), .ack_val_i(ack_val),
    .tx_wr_i(tx_wr), .tx_byte_i(tx_byte), .rx_rd_i(rx_rd), .done_clr_i(done_clr),
    .start_bit_o(start_bit), .rstart_bit_o(rstart_bit), .stop_bit_o(stop_bit),
    .ack_bit_o(ack_bit), .rx_bit_o(rx_bit), .tx_busy_o(tx_busy),
    .buf_full_o(buf_full), .done_o(done), .ack_stat_o(ack_stat), .idle_o(idle_o),
    .rx_byte_o(rx_byte), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe), .sda_oe_o(sda_oe)
  );

  int checks = 0, fails = 0, m_checks = 0, m_fails = 0;
  int exp_q[$];
  int slv_seq = 0, slv_role = 0;
  logic [7:0] slv_rx = 8'h00;
  logic slv_nak = 1'b0;
  int start_cnt = 0, stop_cnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic mchk(input bit ok, input string req, input int act, input int exp);
    m_checks++;
    if (!ok) begin
      m_fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bus device model and monitor: roles 0 none, 1 receive from master, 2 send to master, 3 watch ack bit
  int m_seen = 0, m_role = 0, m_bitc = 0, m_e;
  logic p_scl = 1'b1, p_sda = 1'b1, rise, fall;
  logic [7:0] m_cap = 8'h00;
  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        p_scl = 1'b1; p_sda = 1'b1;
      end else begin
        if (slv_seq != m_seen) begin
          m_seen = slv_seq; m_role = slv_role; m_bitc = 0;
          slave_low = (m_role == 2) ? ~slv_rx[7] : 1'b0;
        end else begin
          if (p_scl && scl_bus && p_sda && !sda_bus) start_cnt++;
          if (p_scl && scl_bus && !p_sda && sda_bus) stop_cnt++;
          rise = scl_bus && !p_scl;
          fall = !scl_bus && p_scl;
          case (m_role)
            1: begin
              if (rise) begin
                if (m_bitc == 0) mchk(buf_full == 1'b1, "R6 data", buf_full, 1);
                if (m_bitc < 8) begin
                  m_cap = {m_cap[6:0], sda_bus};
                  m_bitc++;
                end else if (m_bitc == 8) begin
                  mchk(buf_full == 1'b0 && tx_busy == 1'b1, "R6 ackbit", {buf_full, tx_busy}, 1);
                  m_e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
                  mchk(int'(m_cap) == m_e, "R4 byte", m_cap, m_e);
                  m_bitc = 9;
                end
              end
              if (fall) begin
                if (m_bitc == 8) slave_low = ~slv_nak;
                else if (m_bitc == 9) slave_low = 1'b0;
              end
            end
            2: begin
              if (rise) m_bitc++;
              if (fall) slave_low = (m_bitc < 8) ? ~slv_rx[7 - m_bitc] : 1'b0;
            end
            3: if (rise) begin
              m_e = (exp_q.size() > 0) ? exp_q.pop_front() : -1;
              mchk(256 + int'(sda_bus) == m_e, "R8", 256 + int'(sda_bus), m_e);
            end
            default: ;
          endcase
        end
        p_scl = scl_bus;
        p_sda = sda_bus;
      end
    end
  end

  task automatic drive(input int k, input logic v);
    case (k)
      0: start_req = v;
      1: rstart_req = v;
      2: stop_req = v;
      3: ack_req = v;
      4: rx_req = v;
      default: tx_wr = v;
    endcase
  endtask

  function automatic logic busy_of(input int k);
    case (k)
      0: return start_bit;
      1: return rstart_bit;
      2: return stop_bit;
      3: return ack_bit;
      4: return rx_bit;
      default: return tx_busy;
    endcase
  endfunction

  task automatic slave_set(input int role);
    @(negedge clk);
    slv_role = role;
    slv_seq++;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_op(input int k, input int quarters, input string tag, input bit poke);
    int cnt;
    @(negedge clk);
    drive(k, 1'b1);
    @(negedge clk);
    drive(k, 1'b0);
    cnt = 1;
    chk(idle_o == 1'b0, "R10 busy", idle_o, 0);
    while (busy_of(k) && cnt < 100000) begin
      @(negedge clk);
      cnt++;
      if (poke) start_req = (cnt == 3);
    end
    start_req = 1'b0;
    chk(cnt - 1 == quarters * (int'(reload) + 1), tag, cnt - 1, quarters * (int'(reload) + 1));
  endtask

  task automatic send_byte(input logic [7:0] b, input logic nak, input bit poke);
    slv_nak = nak;
    exp_q.push_back(int'(b));
    slave_set(1);
    tx_byte = b;
    run_op(5, 36, "R2 R4 tx time", poke);
    chk(ack_stat == nak, "R5", ack_stat, nak);
    chk(done == 1'b1, "R4 done", done, 1);
  endtask

  task automatic recv_byte(input logic [7:0] b);
    slv_rx = b;
    slave_set(2);
    run_op(4, 32, "R2 R7 rx time", 1'b0);
    chk(buf_full == 1'b1 && rx_bit == 1'b0, "R7 flags", {buf_full, rx_bit}, 2);
    chk(rx_byte == b, "R7 data", rx_byte, b);
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
    @(negedge clk);
    chk(buf_full == 1'b0, "R7 read", buf_full, 0);
  endtask

  task automatic send_ack(input logic v);
    ack_val = v;
    exp_q.push_back(256 + int'(v));
    slave_set(3);
    run_op(3, 4, "R2 R8 ack time", 1'b0);
  endtask

  task automatic summary(input int extra);
    $display("test done: total=%0d bad=%0d", checks + m_checks + extra, fails + m_fails + extra);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog actual=hung expected=finished");
    summary(1);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(idle_o && !scl_oe && !sda_oe && !buf_full && !done && !tx_busy,
        "R1 reset", {idle_o, scl_oe, sda_oe, buf_full, done, tx_busy}, 6'b100000);

    // start with stray transmit write and stop while busy (R9)
    slave_set(0);
    @(negedge clk); start_req = 1'b1;
    @(negedge clk); start_req = 1'b0;
    tx_byte = 8'hFF; tx_wr = 1'b1; stop_req = 1'b1;
    @(negedge clk); tx_wr = 1'b0; stop_req = 1'b0;
    while (start_bit) @(negedge clk);
    repeat (20) @(negedge clk);
    chk(idle_o && !buf_full && !tx_busy && stop_cnt == 0, "R9 dropped",
        {idle_o, buf_full, tx_busy}, 3'b100);
    chk(start_cnt == 1, "R3 start", start_cnt, 1);
    chk(scl_oe && sda_oe, "R11 hold", {scl_oe, sda_oe}, 3);

    send_byte(8'hA5, 1'b0, 1'b0);
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
    @(negedge clk);
    chk(done == 1'b0, "R12", done, 0);

    // start request in the middle of a byte must vanish (R9)
    s0 = start_cnt;
    send_byte(8'h3C, 1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk(start_cnt == s0 && idle_o, "R9 mid byte", start_cnt, s0);

    slave_set(0);
    run_op(1, 6, "R2 rstart time", 1'b0);
    chk(start_cnt == s0 + 1, "R3 rstart", start_cnt, s0 + 1);
    chk(scl_oe == 1'b1, "R11 rstart hold", scl_oe, 1);

    recv_byte(8'h96);
    send_ack(1'b0);
    recv_byte(8'h5B);
    send_ack(1'b1);

    slave_set(0);
    run_op(2, 4, "R2 stop time", 1'b0);
    chk(stop_cnt == 1, "R3 stop", stop_cnt, 1);
    chk(!scl_oe && !sda_oe && idle_o, "R11 release", {scl_oe, sda_oe}, 0);

    // shortest quarter
    reload = 8'd0;
    slave_set(0);
    run_op(0, 4, "R2 start n0", 1'b0);
    chk(start_cnt == s0 + 2, "R3 start n0", start_cnt, s0 + 2);
    send_byte(8'hC3, 1'b0, 1'b0);
    slave_set(0);
    run_op(2, 4, "R2 stop n0", 1'b0);
    chk(stop_cnt == 2, "R3 stop n0", stop_cnt, 2);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R4 R8 scoreboard", exp_q.size(), 0);
    summary(0);
    $finish;
  end
endmodule